// File: doc/BRIEF.md
# Sectored Instruction Cache Controller

This controller turns an on-chip program RAM of 1024 words of 32 bits into a fully associative instruction cache of eight sectors of 128 words. Each sector carries one address tag, and every word in it has its own valid bit. A miss fetches only the one requested word from external memory, hands it to the core in the same cycle the memory answers, and writes it into the chosen sector. Replacement happens a whole sector at a time. Transfers are always a single word.

The core issues one fetch at a time with `fetch_valid` while `fetch_ready` is high. A hit answers one clock later from the RAM. A miss raises `ext_req` with the word address and completes when `ext_ack` returns. With `cache_en` low, the RAM acts as plain program memory indexed by the low ten address bits, and the cache bookkeeping is left untouched. Software can flush all word valid bits at once. It can also lock or unlock single sectors, so that time-critical code is not evicted. A debug port reads back any sector's tag, tag-valid flag, lock bit, recency rank and any word valid bit. A separate least-recently-used tracker chooses victims and skips locked sectors.

Top module: `sic_cache_ctrl`

## Requirements
- R1: In cache mode, an accepted fetch whose tag matches a sector and whose word is valid gives `fetch_done`=1, `fetch_hit`=1 and the stored word on `fetch_data` in the cycle after acceptance, and raises no `ext_req`.
- R2: An accepted fetch that misses raises `ext_req` in the next cycle, with `ext_addr` equal to the fetch address. It holds `fetch_ready` low until `ext_ack` arrives. In the `ext_ack` cycle it gives `fetch_done`=1, `fetch_hit`=0 and `fetch_data`=`ext_rdata`, and adds no extra cycle.
- R3: The word offset is address bits [6:0] and the tag is bits [31:7]. A miss whose tag matches a sector, but whose word is invalid, writes the word into that same sector and sets only that word's valid bit. No sector is replaced.
- R4: A miss whose tag matches no sector overwrites the victim sector's tag, clears all 128 of its valid bits, then writes and validates the fetched word. Afterwards no two valid sectors share a tag.
- R5: The victim is the least recently used unlocked sector. Any cache-mode access that hits or fills a sector makes it most recent. The debug rank is 0 for the most recent sector and 7 for the least recent. Reset leaves sector i at rank i.
- R6: A locked sector is never chosen as victim and keeps its tag. Its invalid words are still filled on a word miss. Unlocking makes it eligible again.
- R7: When every sector is locked and the tag misses, the word is returned to the core but not cached, so the same address misses again.
- R8: A `flush` pulse clears every word valid bit within one clock. Tags and lock bits are kept.
- R9: With `cache_en`=0, a fetch returns RAM word `fetch_addr[9:0]` one cycle later with `fetch_hit`=1. Tags, valid bits and recency ranks do not change. RAM index = sector*128 + offset.
- R10: The debug outputs show the state selected by `dbg_sector`/`dbg_word` one clock after the selection is applied.
- R11: After reset, no tag or word is valid, no sector is locked, `fetch_ready`=1, and `ext_req` and `fetch_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cache_en | input | 1 | 1 = cache mode, 0 = plain program RAM |
| fetch_valid | input | 1 | Fetch request, taken when `fetch_ready` is 1 |
| fetch_addr | input | 32 | Word address of the fetch |
| fetch_ready | output | 1 | Controller idle and able to accept a fetch |
| fetch_done | output | 1 | Fetch result valid this cycle |
| fetch_hit | output | 1 | Result served from on-chip RAM |
| fetch_data | output | 32 | Returned instruction word |
| ext_req | output | 1 | External single-word fetch pending |
| ext_addr | output | 32 | External fetch word address |
| ext_ack | input | 1 | External memory returns data this cycle |
| ext_rdata | input | 32 | External read data |
| flush | input | 1 | Invalidate all words |
| lock_cmd | input | 1 | Lock sector `lock_sel` |
| unlock_cmd | input | 1 | Unlock sector `lock_sel` |
| lock_sel | input | 3 | Sector addressed by lock commands |
| dbg_sector | input | 3 | Sector selected for debug readback |
| dbg_word | input | 7 | Word selected for valid-bit readback |
| dbg_tag | output | 25 | Tag of the selected sector |
| dbg_tag_valid | output | 1 | Selected sector holds a tag |
| dbg_word_valid | output | 1 | Valid bit of the selected word |
| dbg_locked | output | 1 | Lock bit of the selected sector |
| dbg_age | output | 3 | Recency rank of the selected sector |

## Verification
The bench first fills a sector one word at a time. It checks that a word miss in a matching sector neither evicts it nor disturbs the other valid words. A design that replaced on every miss would lose the earlier word and fail the debug readback. It then walks the recency order through a full set of evictions, including after a lock. A tracker that aged sectors wrongly, or that evicted a locked sector, would show up in the per-sector ranks and in the next victim. It also checks the all-locked pass-through, which must not cache, the flush, which must keep tags, and plain-RAM mode, which must leave the ranks frozen.

// File: rtl/sic_pkg.sv
package sic_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_MISS = 1'b1
  } sic_state_e;
endpackage

// File: rtl/sic_data_ram.sv
module sic_data_ram #(
  parameter int DATA_W = 32,
  parameter int AW     = 10
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/sic_sector_match.sv
module sic_sector_match #(
  parameter int SECTORS = 8,
  parameter int TAG_W   = 25,
  parameter int IDX_W   = 3
) (
  input  logic [SECTORS-1:0][TAG_W-1:0] tag_q,
  input  logic [SECTORS-1:0]            tag_ok,
  input  logic [TAG_W-1:0]              look_tag,
  output logic                          match,
  output logic [IDX_W-1:0]              match_idx,
  output logic [SECTORS-1:0]            match_vec
);
  always_comb begin
    match     = 1'b0;
    match_idx = '0;
    for (int i = 0; i < SECTORS; i++) begin
      match_vec[i] = tag_ok[i] && (tag_q[i] == look_tag);
      if (match_vec[i]) begin
        match     = 1'b1;
        match_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/sic_lru.sv
module sic_lru #(
  parameter int SECTORS = 8,
  parameter int IDX_W   = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          touch,
  input  logic [IDX_W-1:0]              touch_idx,
  input  logic [SECTORS-1:0]            lock_mask,
  output logic [IDX_W-1:0]              victim_idx,
  output logic                          victim_ok,
  output logic [SECTORS-1:0][IDX_W-1:0] age
);
  // Rank 0 is most recent; the touched sector moves to 0, younger ones age by one.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SECTORS; i++) age[i] <= IDX_W'(i);
    end else if (touch) begin
      for (int i = 0; i < SECTORS; i++) begin
        if (IDX_W'(i) == touch_idx) age[i] <= '0;
        else if (age[i] < age[touch_idx]) age[i] <= age[i] + 1'b1;
      end
    end
  end

  logic             found;
  logic [IDX_W-1:0] best_age;
  logic [IDX_W-1:0] best_idx;

  always_comb begin
    found    = 1'b0;
    best_age = '0;
    best_idx = '0;
    for (int i = 0; i < SECTORS; i++) begin
      if (!lock_mask[i] && (!found || age[i] > best_age)) begin
        found    = 1'b1;
        best_age = age[i];
        best_idx = IDX_W'(i);
      end
    end
  end

  assign victim_ok  = found;
  assign victim_idx = best_idx;
endmodule

// File: rtl/sic_cache_ctrl.sv
module sic_cache_ctrl
  import sic_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int DATA_W       = 32,
  parameter int SECTORS      = 8,
  parameter int SECTOR_WORDS = 128
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 cache_en,
  input  logic                                 fetch_valid,
  input  logic [ADDR_W-1:0]                    fetch_addr,
  output logic                                 fetch_ready,
  output logic                                 fetch_done,
  output logic                                 fetch_hit,
  output logic [DATA_W-1:0]                    fetch_data,
  output logic                                 ext_req,
  output logic [ADDR_W-1:0]                    ext_addr,
  input  logic                                 ext_ack,
  input  logic [DATA_W-1:0]                    ext_rdata,
  input  logic                                 flush,
  input  logic                                 lock_cmd,
  input  logic                                 unlock_cmd,
  input  logic [$clog2(SECTORS)-1:0]           lock_sel,
  input  logic [$clog2(SECTORS)-1:0]           dbg_sector,
  input  logic [$clog2(SECTOR_WORDS)-1:0]      dbg_word,
  output logic [ADDR_W-$clog2(SECTOR_WORDS)-1:0] dbg_tag,
  output logic                                 dbg_tag_valid,
  output logic                                 dbg_word_valid,
  output logic                                 dbg_locked,
  output logic [$clog2(SECTORS)-1:0]           dbg_age
);
  localparam int OFF_W = $clog2(SECTOR_WORDS);
  localparam int IDX_W = $clog2(SECTORS);
  localparam int TAG_W = ADDR_W - OFF_W;
  localparam int RAM_W = IDX_W + OFF_W;

  // Cache bookkeeping
  logic [SECTORS-1:0][TAG_W-1:0]        tag_q;
  logic [SECTORS-1:0]                   tag_ok;
  logic [SECTORS-1:0]                   locked;
  logic [SECTORS-1:0][SECTOR_WORDS-1:0] wvalid;

  sic_state_e        state;
  logic              hit_done_q;
  logic [ADDR_W-1:0] miss_addr_q;
  logic              miss_cache_q;
  logic [IDX_W-1:0]  miss_idx_q;

  logic [TAG_W-1:0] req_tag;
  logic [OFF_W-1:0] req_off;
  assign req_tag = fetch_addr[ADDR_W-1:OFF_W];
  assign req_off = fetch_addr[OFF_W-1:0];

  logic               tag_match;
  logic [IDX_W-1:0]   match_idx;
  logic [SECTORS-1:0] match_vec;

  sic_sector_match #(.SECTORS(SECTORS), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_match (
    .tag_q    (tag_q),
    .tag_ok   (tag_ok),
    .look_tag (req_tag),
    .match    (tag_match),
    .match_idx(match_idx),
    .match_vec(match_vec)
  );

  logic                          touch;
  logic [IDX_W-1:0]              tgt_idx;
  logic [IDX_W-1:0]              victim_idx;
  logic                          victim_ok;
  logic [SECTORS-1:0][IDX_W-1:0] age;

  sic_lru #(.SECTORS(SECTORS), .IDX_W(IDX_W)) u_lru (
    .clk       (clk),
    .rst       (rst),
    .touch     (touch),
    .touch_idx (tgt_idx),
    .lock_mask (locked),
    .victim_idx(victim_idx),
    .victim_ok (victim_ok),
    .age       (age)
  );

  logic accept, word_hit, on_chip, tgt_ok, replace, fill;
  assign accept   = fetch_valid && (state == ST_IDLE);
  assign word_hit = tag_match && wvalid[match_idx][req_off];
  assign on_chip  = !cache_en || word_hit;
  assign tgt_ok   = tag_match || victim_ok;
  assign tgt_idx  = tag_match ? match_idx : victim_idx;
  assign replace  = accept && cache_en && !tag_match && victim_ok;
  assign touch    = accept && cache_en && tgt_ok;
  assign fill     = (state == ST_MISS) && ext_ack && miss_cache_q;

  logic [RAM_W-1:0]  ram_raddr;
  logic [RAM_W-1:0]  ram_waddr;
  logic [DATA_W-1:0] ram_q;
  assign ram_raddr = cache_en ? {match_idx, req_off} : fetch_addr[RAM_W-1:0];
  assign ram_waddr = {miss_idx_q, miss_addr_q[OFF_W-1:0]};

  sic_data_ram #(.DATA_W(DATA_W), .AW(RAM_W)) u_ram (
    .clk  (clk),
    .we   (fill),
    .waddr(ram_waddr),
    .wdata(ext_rdata),
    .raddr(ram_raddr),
    .rdata(ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      hit_done_q   <= 1'b0;
      miss_addr_q  <= '0;
      miss_cache_q <= 1'b0;
      miss_idx_q   <= '0;
      tag_q        <= '0;
      tag_ok       <= '0;
      wvalid       <= '0;
      locked       <= '0;
    end else begin
      hit_done_q <= accept && on_chip;
      case (state)
        ST_IDLE: begin
          if (accept && !on_chip) begin
            state        <= ST_MISS;
            miss_addr_q  <= fetch_addr;
            miss_cache_q <= tgt_ok;
            miss_idx_q   <= tgt_idx;
          end
          if (replace) begin
            tag_q[victim_idx]  <= req_tag;
            tag_ok[victim_idx] <= 1'b1;
            wvalid[victim_idx] <= '0;
          end
        end
        default: begin
          if (ext_ack) begin
            state <= ST_IDLE;
            if (miss_cache_q) wvalid[miss_idx_q][miss_addr_q[OFF_W-1:0]] <= 1'b1;
          end
        end
      endcase
      if (lock_cmd) locked[lock_sel] <= 1'b1;
      else if (unlock_cmd) locked[lock_sel] <= 1'b0;
      if (flush) wvalid <= '0;
    end
  end

  // Miss data is forwarded from the external port so no cycle is added.
  assign fetch_ready = (state == ST_IDLE);
  assign ext_req     = (state == ST_MISS);
  assign ext_addr    = miss_addr_q;
  assign fetch_done  = hit_done_q || (ext_req && ext_ack);
  assign fetch_hit   = hit_done_q;
  assign fetch_data  = hit_done_q ? ram_q : ext_rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      dbg_tag        <= '0;
      dbg_tag_valid  <= 1'b0;
      dbg_word_valid <= 1'b0;
      dbg_locked     <= 1'b0;
      dbg_age        <= '0;
    end else begin
      dbg_tag        <= tag_q[dbg_sector];
      dbg_tag_valid  <= tag_ok[dbg_sector];
      dbg_word_valid <= wvalid[dbg_sector][dbg_word];
      dbg_locked     <= locked[dbg_sector];
      dbg_age        <= age[dbg_sector];
    end
  end
endmodule

// File: rtl/sic_checker.sv
module sic_checker #(
  parameter int ADDR_W       = 32,
  parameter int SECTORS      = 8,
  parameter int SECTOR_WORDS = 128,
  parameter int TAG_W        = 25,
  parameter int IDX_W        = 3
) (
  input logic                                 clk,
  input logic                                 rst,
  input logic                                 cache_en,
  input logic                                 fetch_valid,
  input logic                                 fetch_ready,
  input logic                                 fetch_hit,
  input logic                                 ext_req,
  input logic                                 ext_ack,
  input logic [ADDR_W-1:0]                    ext_addr,
  input logic                                 flush,
  input logic [SECTORS-1:0][TAG_W-1:0]        tag_q,
  input logic [SECTORS-1:0]                   tag_ok,
  input logic [SECTORS-1:0][SECTOR_WORDS-1:0] wvalid,
  input logic [SECTORS-1:0]                   locked,
  input logic [SECTORS-1:0][IDX_W-1:0]        age,
  input logic [SECTORS-1:0]                   match_vec,
  input logic [IDX_W-1:0]                     victim_idx,
  input logic                                 victim_ok
);
  logic [SECTORS-1:0] rank_seen;
  always_comb begin
    rank_seen = '0;
    for (int i = 0; i < SECTORS; i++) rank_seen[age[i]] = 1'b1;
  end

  assert_hit_after_accept_R1: assert property (@(posedge clk) disable iff (rst)
    fetch_hit |-> $past(fetch_valid && fetch_ready));

  assert_hit_no_ext_R1: assert property (@(posedge clk) disable iff (rst)
    fetch_hit |-> !ext_req);

  assert_miss_from_request_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(ext_req) |-> $past(fetch_valid && fetch_ready));

  assert_ext_addr_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (ext_req && !ext_ack) |=> (ext_req && $stable(ext_addr)));

  assert_tag_unique_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match_vec));

  assert_ranks_distinct_R5: assert property (@(posedge clk) disable iff (rst)
    &rank_seen);

  assert_victim_unlocked_R6: assert property (@(posedge clk) disable iff (rst)
    victim_ok |-> !locked[victim_idx]);

  assert_all_locked_no_victim_R7: assert property (@(posedge clk) disable iff (rst)
    (&locked) |-> !victim_ok);

  assert_flush_clears_R8: assert property (@(posedge clk) disable iff (rst)
    flush |=> (wvalid == '0));

  assert_ram_mode_frozen_R9: assert property (@(posedge clk) disable iff (rst)
    (!cache_en && fetch_ready && !flush) |=>
      ($stable(tag_q) && $stable(tag_ok) && $stable(wvalid) && $stable(age)));
endmodule

bind sic_cache_ctrl sic_checker #(
  .ADDR_W(ADDR_W), .SECTORS(SECTORS), .SECTOR_WORDS(SECTOR_WORDS),
  .TAG_W(TAG_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst(rst), .cache_en(cache_en), .fetch_valid(fetch_valid),
  .fetch_ready(fetch_ready), .fetch_hit(fetch_hit), .ext_req(ext_req),
  .ext_ack(ext_ack), .ext_addr(ext_addr), .flush(flush), .tag_q(tag_q),
  .tag_ok(tag_ok), .wvalid(wvalid), .locked(locked), .age(age),
  .match_vec(match_vec), .victim_idx(victim_idx), .victim_ok(victim_ok)
);

// File: tb/tb_sic_cache_ctrl.sv
`timescale 1ns/1ps
module tb_sic_cache_ctrl;
  logic        clk, rst, cache_en, fetch_valid, fetch_ready, fetch_done, fetch_hit;
  logic [31:0] fetch_addr, fetch_data, ext_addr, ext_rdata;
  logic        ext_req, ext_ack, flush, lock_cmd, unlock_cmd;
  logic [2:0]  lock_sel, dbg_sector, dbg_age;
  logic [6:0]  dbg_word;
  logic [24:0] dbg_tag;
  logic        dbg_tag_valid, dbg_word_valid, dbg_locked;

  sic_cache_ctrl dut (
    .clk(clk), .rst(rst), .cache_en(cache_en), .fetch_valid(fetch_valid),
    .fetch_addr(fetch_addr), .fetch_ready(fetch_ready), .fetch_done(fetch_done),
    .fetch_hit(fetch_hit), .fetch_data(fetch_data), .ext_req(ext_req),
    .ext_addr(ext_addr), .ext_ack(ext_ack), .ext_rdata(ext_rdata), .flush(flush),
    .lock_cmd(lock_cmd), .unlock_cmd(unlock_cmd), .lock_sel(lock_sel),
    .dbg_sector(dbg_sector), .dbg_word(dbg_word), .dbg_tag(dbg_tag),
    .dbg_tag_valid(dbg_tag_valid), .dbg_word_valid(dbg_word_valid),
    .dbg_locked(dbg_locked), .dbg_age(dbg_age)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  bit done_flag = 0;

  // Behavioural reference model
  logic [24:0] m_tag [8];
  bit          m_tv  [8];
  bit          m_lock[8];
  bit          m_val [8][128];
  logic [31:0] m_mem [1024];
  int          m_order[$];
  bit          m_cache_en = 0;
  bit          exp_ext_req = 0;

  task automatic check_eq(input string req, input string what,
                          input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ext_word(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h13579BDF;
  endfunction

  function automatic logic [31:0] mk(input int t, input int o);
    return {25'(t), 7'(o)};
  endfunction

  function automatic int age_of(input int s);
    foreach (m_order[i]) if (m_order[i] == s) return i;
    return -1;
  endfunction

  task automatic m_touch(input int s);
    int p = age_of(s);
    m_order.delete(p);
    m_order.push_front(s);
  endtask

  function automatic int pick_victim();
    for (int i = m_order.size() - 1; i >= 0; i--)
      if (!m_lock[m_order[i]]) return m_order[i];
    return -1;
  endfunction

  function automatic int find_tag(input logic [24:0] t);
    for (int s = 0; s < 8; s++) if (m_tv[s] && m_tag[s] == t) return s;
    return -1;
  endfunction

  // Per-clock comparison of the handshake outputs against the model (R2)
  always @(posedge clk) begin
    #1;
    if (!rst && !done_flag) begin
      check_eq("R2", "ext_req per clock", 64'(ext_req), 64'(exp_ext_req));
      check_eq("R2", "fetch_ready per clock", 64'(fetch_ready), 64'(!exp_ext_req));
    end
  end

  task automatic do_fetch(input logic [31:0] a, input int lat, input string req);
    logic [24:0] t = a[31:7];
    int off = int'(a[6:0]);
    int s = -1;
    int tgt = -1;
    bit hit;
    logic [31:0] d = '0;
    if (!m_cache_en) begin
      hit = 1;
      d = m_mem[a[9:0]];
    end else begin
      s = find_tag(t);
      hit = (s >= 0) && m_val[s][off];
      if (hit) d = m_mem[s*128 + off];
      tgt = (s >= 0) ? s : pick_victim();
    end
    @(negedge clk);
    fetch_valid = 1'b1;
    fetch_addr  = a;
    if (!hit) exp_ext_req = 1;
    if (m_cache_en && tgt >= 0) begin
      if (s < 0) begin
        m_tag[tgt] = t;
        m_tv[tgt]  = 1;
        for (int w = 0; w < 128; w++) m_val[tgt][w] = 0;
      end
      m_touch(tgt);
    end
    @(negedge clk);
    fetch_valid = 1'b0;
    if (hit) begin
      check_eq(req, "hit done", 64'(fetch_done), 64'd1);
      check_eq(req, "hit flag", 64'(fetch_hit), 64'd1);
      check_eq(req, "hit data", 64'(fetch_data), 64'(d));
    end else begin
      check_eq(req, "miss not done early", 64'(fetch_done), 64'd0);
      check_eq(req, "miss ext_addr", 64'(ext_addr), 64'(a));
      repeat (lat) @(negedge clk);
      ext_ack     = 1'b1;
      ext_rdata   = ext_word(a);
      exp_ext_req = 0;
      #1;
      check_eq(req, "miss done on ack", 64'(fetch_done), 64'd1);
      check_eq(req, "miss hit flag", 64'(fetch_hit), 64'd0);
      check_eq(req, "miss data", 64'(fetch_data), 64'(ext_word(a)));
      if (tgt >= 0) begin
        m_mem[tgt*128 + off] = ext_word(a);
        m_val[tgt][off] = 1;
      end
      @(negedge clk);
      ext_ack   = 1'b0;
      ext_rdata = '0;
    end
  endtask

  task automatic dbg_all(input int word, input string req);
    @(negedge clk);
    for (int s = 0; s < 8; s++) begin
      dbg_sector = 3'(s);
      dbg_word   = 7'(word);
      @(negedge clk);
      check_eq(req, $sformatf("sector %0d tag valid", s), 64'(dbg_tag_valid), 64'(m_tv[s]));
      if (m_tv[s]) check_eq(req, $sformatf("sector %0d tag", s), 64'(dbg_tag), 64'(m_tag[s]));
      check_eq(req, $sformatf("sector %0d locked", s), 64'(dbg_locked), 64'(m_lock[s]));
      check_eq(req, $sformatf("sector %0d rank", s), 64'(dbg_age), 64'(age_of(s)));
      check_eq(req, $sformatf("sector %0d word %0d valid", s, word),
               64'(dbg_word_valid), 64'(m_val[s][word]));
    end
  endtask

  task automatic set_lock(input int s, input bit on);
    @(negedge clk);
    lock_sel   = 3'(s);
    lock_cmd   = on;
    unlock_cmd = !on;
    m_lock[s]  = on;
    @(negedge clk);
    lock_cmd   = 1'b0;
    unlock_cmd = 1'b0;
  endtask

  task automatic report();
    done_flag = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected completion");
    report();
  end

  initial begin
    int lk;
    int found;
    rst = 1; cache_en = 0; fetch_valid = 0; fetch_addr = '0; ext_ack = 0;
    ext_rdata = '0; flush = 0; lock_cmd = 0; unlock_cmd = 0; lock_sel = '0;
    dbg_sector = '0; dbg_word = '0;
    for (int s = 0; s < 8; s++) begin
      m_tag[s] = '0; m_tv[s] = 0; m_lock[s] = 0; m_order.push_back(s);
      for (int w = 0; w < 128; w++) m_val[s][w] = 0;
    end
    for (int i = 0; i < 1024; i++) m_mem[i] = '0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R11: reset state
    check_eq("R11", "fetch_ready", 64'(fetch_ready), 64'd1);
    check_eq("R11", "ext_req", 64'(ext_req), 64'd0);
    check_eq("R11", "fetch_done", 64'(fetch_done), 64'd0);
    // R10: debug output moves one clock after the selection
    dbg_sector = 3'd3;
    #1;
    check_eq("R10", "rank before edge", 64'(dbg_age), 64'd0);
    @(negedge clk);
    check_eq("R10", "rank after edge", 64'(dbg_age), 64'd3);
    dbg_all(0, "R11");

    // Cache mode: tag miss into LRU sector, then hit, then word miss
    cache_en = 1; m_cache_en = 1;
    do_fetch(mk(16, 5), 3, "R4");
    do_fetch(mk(16, 5), 0, "R1");
    do_fetch(mk(16, 6), 1, "R3");
    dbg_all(5, "R3");
    dbg_all(6, "R3");
    for (int k = 17; k <= 23; k++) do_fetch(mk(k, 0), k % 4, "R4");
    dbg_all(0, "R5");
    do_fetch(mk(16, 5), 0, "R5");
    do_fetch(mk(24, 1), 2, "R5");
    dbg_all(0, "R4");
    do_fetch(mk(17, 0), 0, "R4");
    dbg_all(0, "R5");

    // R6: lock the least recent sector, next eviction skips it
    lk = m_order[m_order.size() - 1];
    set_lock(lk, 1);
    do_fetch(mk(32, 2), 1, "R6");
    dbg_all(2, "R6");
    do_fetch({m_tag[lk], 7'd9}, 2, "R6");
    do_fetch({m_tag[lk], 7'd9}, 0, "R6");
    dbg_all(9, "R6");

    // R9: plain RAM mode
    cache_en = 0; m_cache_en = 0;
    @(negedge clk);
    do_fetch(32'h0000_0385, 0, "R9");
    do_fetch(32'hABCD_0381, 0, "R9");
    dbg_all(5, "R9");
    cache_en = 1; m_cache_en = 1;

    // R8: flush keeps tags, clears words
    @(negedge clk);
    flush = 1;
    for (int s = 0; s < 8; s++) for (int w = 0; w < 128; w++) m_val[s][w] = 0;
    @(negedge clk);
    flush = 0;
    dbg_all(5, "R8");
    do_fetch(mk(16, 5), 1, "R8");
    dbg_all(5, "R8");

    // R7: all locked, pass-through without caching
    for (int s = 0; s < 8; s++) if (!m_lock[s]) set_lock(s, 1);
    do_fetch(mk(48, 3), 2, "R7");
    do_fetch(mk(48, 3), 0, "R7");
    dbg_all(3, "R7");
    found = find_tag(25'd48);
    check_eq("R7", "tag not cached", 64'(found), 64'(-1));
    for (int s = 0; s < 8; s++) set_lock(s, 0);
    do_fetch(mk(48, 3), 1, "R6");
    do_fetch(mk(48, 3), 0, "R6");
    dbg_all(3, "R6");

    repeat (3) @(negedge clk);
    report();
  end
endmodule